// File: doc/BRIEF.md
# Table-driven space vector PWM generator

This block drives the six gate signals of a three-phase two-level inverter by space vector modulation without any run-time trigonometry. A symmetric up-down carrier sets the switching period. A sample counter, advanced once per carrier period, gives the position of the reference inside the current 60-degree sector, and a sector counter walks through the six sectors in turn. For each position, the dwell times of the two active vectors bounding the sector are taken from a constant table built at elaboration. The zero-vector time is whatever remains of the half period.

The dwell times become three per-leg thresholds. Comparing them with the carrier gives a seven-segment pattern that is mirrored about the carrier peak. Each leg command then passes through a dead-band stage, which produces a complementary upper/lower pair with a programmable gap. The sector and the sample index are brought out so that surrounding logic can follow the rotation.

Top module: `svpwm_gen`

## Requirements
- R1: The sample index starts at 0. It advances by one every 2*PEAK clocks, in the clock where the falling carrier reaches 0. After SAMPLES-1 (33 by default) it returns to 0, and the sector advances in that same clock.
- R2: The sector output runs 1,2,3,4,5,6 and then returns to 1. It never holds any other value.
- R3: The carrier starts at 0 after reset or enable. It rises by one per clock to PEAK, then falls by one per clock back to 0. In each clock, leg command i is 1 when carrier >= threshold i. The thresholds are lo = (PEAK-ta-tb)/2 (rounded down), mid = lo+first and hi = lo+ta+tb. Here first is the dwell of the single-leg bounding vector.
- R4: For sample k, let u = floor(k*256/SAMPLES). Define S(x) = floor(4*P*4096/(165888000-P)) with P = 15x(11520-15x). Then tb = floor(MOD*PEAK*S(u)/1048576) and ta = floor(MOD*PEAK*S(256-u)/1048576). Here ta is the dwell of the vector that opens the sector and tb that of the vector that closes it.
- R5: The vectors are given as the legs that are high: V1=a, V2=a+b, V3=b, V4=b+c, V5=c, V6=a+c. Sector s is bounded by Vs and V(s mod 6 + 1). The leg of the single-leg bounding vector takes lo. The other leg high in the two-leg bounding vector takes mid. The remaining leg takes hi. Bit 0 of upper and lower is leg a, bit 1 is leg b and bit 2 is leg c.
- R6: Upper and lower of a leg are never high together.
- R7: Whenever a leg command differs from the last value seen, that value is replaced and a wait of dead clocks is loaded. Both gates of that leg stay low in that clock, and they stay low while the wait counts down to 0. A further change during the wait reloads it. After that, each clock sets upper to the stored command and lower to its inverse.
- R8: While rst_n is low, and in the clock after any clock in which en is low, all six gates are low, the sector is 1 and the sample index is 0. The carrier then restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears the block |
| dead | input | DT_W | Dead band length in clocks |
| upper | output | 3 | Upper switch gates, legs a,b,c at bits 0,1,2 |
| lower | output | 3 | Lower switch gates, legs a,b,c at bits 0,1,2 |
| sector | output | 3 | Active sector, 1 to 6 |
| sample | output | $clog2(SAMPLES) | Position within the sector |

## Verification
The bench sweeps more than a full revolution at several dead-band settings. It compares every gate, the sector and the sample index in every clock against an arithmetic model of the carrier, the table and the vector sequence. A wrong sector-to-leg mapping would put the wrong leg first in the pattern, and an off-by-one in the sample wrap would drift the sector boundaries by whole carrier periods. A dead setting longer than the pulses near the carrier peak forces command reversals inside the wait. A stage that does not reload its wait would then release a gate too early. Dropping enable in mid-revolution checks that the rotation restarts at sector 1 with no gate left high.

// File: rtl/svpwm_gen.sv
module svpwm_gen #(
  parameter int PEAK    = 255,
  parameter int SAMPLES = 34,
  parameter int MOD     = 232,
  parameter int DT_W    = 8,
  localparam int CW = $clog2(PEAK + 1),
  localparam int SW = $clog2(SAMPLES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DT_W-1:0] dead,
  output logic [2:0]      upper,
  output logic [2:0]      lower,
  output logic [2:0]      sector,
  output logic [SW-1:0]   sample
);

  localparam logic [CW:0]   PEAK_V = (CW+1)'(PEAK);
  localparam logic [CW-1:0] TOP_M1 = CW'(PEAK - 1);
  localparam logic [SW-1:0] LAST_S = SW'(SAMPLES - 1);

  function automatic longint sin_q12(input longint u);
    longint p;
    p = 15 * u * (11520 - 15 * u);
    return (4 * p * 4096) / (165888000 - p);
  endfunction

  function automatic int dwell(input int k, input bit lead);
    longint u;
    u = (longint'(k) * 256) / SAMPLES;
    if (lead) u = 256 - u;
    return int'((longint'(MOD) * PEAK * sin_q12(u)) / (256 * 4096));
  endfunction

  logic [CW-1:0] ta_rom [SAMPLES];
  logic [CW-1:0] tb_rom [SAMPLES];

  for (genvar k = 0; k < SAMPLES; k++) begin : g_rom
    assign ta_rom[k] = CW'(dwell(k, 1'b1));
    assign tb_rom[k] = CW'(dwell(k, 1'b0));
  end

  logic [CW-1:0] cnt;
  logic          up;

  logic [CW:0] ta, tb, tsum, lo, mid, hi;
  logic [CW:0] th [3];
  logic [2:0]  cmd;

  assign ta   = {1'b0, ta_rom[sample]};
  assign tb   = {1'b0, tb_rom[sample]};
  assign tsum = ta + tb;
  assign lo   = (PEAK_V - tsum) >> 1;
  assign mid  = lo + (sector[0] ? ta : tb);
  assign hi   = lo + tsum;

  always_comb begin
    case (sector)
      3'd2:    begin th[0] = mid; th[1] = lo;  th[2] = hi;  end
      3'd3:    begin th[0] = hi;  th[1] = lo;  th[2] = mid; end
      3'd4:    begin th[0] = hi;  th[1] = mid; th[2] = lo;  end
      3'd5:    begin th[0] = mid; th[1] = hi;  th[2] = lo;  end
      3'd6:    begin th[0] = lo;  th[1] = hi;  th[2] = mid; end
      default: begin th[0] = lo;  th[1] = mid; th[2] = hi;  end
    endcase
  end

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign cmd[i] = {1'b0, cnt} >= th[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      up     <= 1'b1;
      sample <= '0;
      sector <= 3'd1;
    end else if (!en) begin
      cnt    <= '0;
      up     <= 1'b1;
      sample <= '0;
      sector <= 3'd1;
    end else if (up) begin
      cnt <= cnt + 1'b1;
      if (cnt == TOP_M1) up <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        up <= 1'b1;
        if (sample == LAST_S) begin
          sample <= '0;
          sector <= (sector == 3'd6) ? 3'd1 : sector + 3'd1;
        end else begin
          sample <= sample + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_leg
    logic            last;
    logic [DT_W-1:0] wt;
    logic            hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last <= 1'b0;
        wt   <= '0;
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else if (!en) begin
        last <= 1'b0;
        wt   <= '0;
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else if (cmd[i] != last) begin
        last <= cmd[i];
        wt   <= dead;
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else if (wt != '0) begin
        wt   <= wt - 1'b1;
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else begin
        hi_q <= last;
        lo_q <= ~last;
      end
    end

    assign upper[i] = hi_q;
    assign lower[i] = lo_q;
  end

endmodule

// File: rtl/svpwm_gen_chk.sv
module svpwm_gen_chk #(
  parameter int SAMPLES = 34,
  parameter int SW = $clog2(SAMPLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [2:0]    upper,
  input logic [2:0]    lower,
  input logic [2:0]    sector,
  input logic [SW-1:0] sample
);

  p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upper & lower) == 3'b000);

  p_break_make_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((upper & ~$past(upper) & $past(lower)) == 3'b000) &&
             ((lower & ~$past(lower) & $past(upper)) == 3'b000));

  p_sector_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sector >= 3'd1 && sector <= 3'd6);

  p_sector_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sector) && $past(en)) |->
      sample == '0 &&
      sector == (($past(sector) == 3'd6) ? 3'd1 : $past(sector) + 3'd1));

  p_sample_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sample) < SAMPLES);

  p_sample_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sample) && $past(en)) |->
      sample == (($past(sample) == SW'(SAMPLES - 1)) ? '0 : $past(sample) + 1'b1));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (upper | lower) == 3'b000 && sector == 3'd1 && sample == '0);

endmodule

bind svpwm_gen svpwm_gen_chk #(.SAMPLES(SAMPLES), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .upper(upper), .lower(lower),
  .sector(sector), .sample(sample)
);

// File: tb/svpwm_gen_tb.sv
module svpwm_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PEAK    = 20;
  localparam int SAMPLES = 34;
  localparam int MOD     = 232;
  localparam int DT_W    = 8;
  localparam int SW      = $clog2(SAMPLES);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [DT_W-1:0] dead = 8'd2;
  logic [2:0]      upper, lower, sector;
  logic [SW-1:0]   sample;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit chk_on = 1'b0, done = 1'b0;

  svpwm_gen #(.PEAK(PEAK), .SAMPLES(SAMPLES), .MOD(MOD), .DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dead(dead),
    .upper(upper), .lower(lower), .sector(sector), .sample(sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint s_of(input longint x);
    longint p;
    p = 15 * x * (11520 - 15 * x);
    return (4 * p * 4096) / (165888000 - p);
  endfunction

  function automatic int dwell_of(input int k, input bit opening);
    longint u;
    u = (longint'(k) * 256) / SAMPLES;
    return int'((longint'(MOD) * PEAK * s_of(opening ? 256 - u : u)) / 1048576);
  endfunction

  function automatic bit [2:0] legs_of(input int v);
    case (v)
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b010;
      4: return 3'b110;
      5: return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  int m_cnt = 0, m_samp = 0, m_sect = 1;
  bit m_up = 1'b1;
  bit [2:0] m_last = '0, m_hi = '0, m_lo = '0;
  int m_wt [3] = '{0, 0, 0};

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !en) begin
      m_cnt = 0; m_up = 1'b1; m_samp = 0; m_sect = 1;
      m_last = '0; m_hi = '0; m_lo = '0;
      for (int i = 0; i < 3; i++) m_wt[i] = 0;
    end else begin
      int ta, tb, lo, first, thr;
      bit [2:0] v1, v2, single, c;
      ta = dwell_of(m_samp, 1'b1);
      tb = dwell_of(m_samp, 1'b0);
      lo = (PEAK - ta - tb) / 2;
      v1 = legs_of(m_sect);
      v2 = legs_of(m_sect == 6 ? 1 : m_sect + 1);
      single = ($countones(v1) == 1) ? v1 : v2;
      first  = (single == v1) ? ta : tb;
      for (int i = 0; i < 3; i++) begin
        if (single[i]) thr = lo;
        else if (v1[i] | v2[i]) thr = lo + first;
        else thr = lo + ta + tb;
        c[i] = (m_cnt >= thr);
      end
      for (int i = 0; i < 3; i++) begin
        if (c[i] != m_last[i]) begin
          m_last[i] = c[i]; m_wt[i] = int'(dead); m_hi[i] = 1'b0; m_lo[i] = 1'b0;
        end else if (m_wt[i] != 0) begin
          m_wt[i]--; m_hi[i] = 1'b0; m_lo[i] = 1'b0;
        end else begin
          m_hi[i] = m_last[i]; m_lo[i] = ~m_last[i];
        end
      end
      if (m_up) begin
        m_cnt++;
        if (m_cnt == PEAK) m_up = 1'b0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_up = 1'b1;
          if (m_samp == SAMPLES - 1) begin
            m_samp = 0;
            m_sect = (m_sect == 6) ? 1 : m_sect + 1;
          end else m_samp++;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R1 sample index", int'(sample), m_samp);
      check("R2 sector", int'(sector), m_sect);
      check("R3 R4 R5 R7 upper gates", int'(upper), int'(m_hi));
      check("R3 R4 R5 R7 lower gates", int'(lower), int'(m_lo));
      check("R6 no overlap", int'(upper & lower), 0);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset gates", int'({upper, lower}), 0);
    check("R8 reset sector", int'(sector), 1);
    check("R8 reset sample", int'(sample), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 idle gates", int'({upper, lower}), 0);
    check("R8 idle sector", int'(sector), 1);
    chk_on = 1'b1;
    en = 1'b1;
    repeat (9000) @(negedge clk);
    dead = 8'd0;
    repeat (9000) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 disabled gates", int'({upper, lower}), 0);
    check("R8 disabled sector", int'(sector), 1);
    check("R8 disabled sample", int'(sample), 0);
    en = 1'b1;
    dead = 8'd12;
    repeat (9000) @(negedge clk);
    dead = 8'd255;
    repeat (3000) @(negedge clk);
    dead = 8'd1;
    repeat (9000) @(negedge clk);
    dead = 8'd5;
    repeat (4000) @(negedge clk);
    finish_run();
  end
endmodule